// File: doc/BRIEF.md
# Segment Selector Address Translator

This block converts a 16-bit segment selector plus a 32-bit effective address into a 32-bit linear address, using segmented protected-mode addressing. It keeps two table registers, one for the global descriptor table and one for the local descriptor table. Each holds a 32-bit base and a 16-bit limit, and each is loaded through a one-cycle write port.

A request arrives over a valid/ready handshake. The block splits the selector into its fields and picks a table. It forms the descriptor address and checks that the whole 8-byte descriptor lies inside the table limit. It then fetches the descriptor as two 32-bit beats over a req/ack memory read port, and checks the offset against the segment limit, scaled when the granularity bit is set. The response reports the linear address, the requested privilege level, the access bits and a status code. Only one request is in flight at a time.

Top module: `seg_xlate`

## Requirements
- R1: The selector fields are: privilege level in bits 1:0, table indicator in bit 2, descriptor index in bits 15:3. The response carries the privilege level unchanged on `rs_rpl`.
- R2: A pulse on `tw_en` loads `tw_base` and `tw_limit` into the global table register when `tw_sel`=0, and into the local one when `tw_sel`=1. Both registers reset to base 0 and limit 0. A request uses the values that the selected register held before the clock edge that accepts it, so a write in that same cycle applies only to later requests.
- R3: Table indicator 0 selects the global table and 1 selects the local one. The descriptor address is table base + index*8, modulo 2^32. The low word is read first at that address, then the high word at that address + 4.
- R4: When index*8+7 exceeds the selected table limit, the response has status 1 (table fault), linear address 0 and access 0, and no memory read is issued.
- R5: The descriptor is decoded as follows. The low word is the segment base. In the high word, bits 19:0 are the limit and bit 20 is the granularity flag. The response access field is {1'b0, high word bits 31:21}.
- R6: The effective segment limit is the limit when granularity is 0, and (limit<<12)|0xFFF when it is 1. An offset greater than the effective limit gives status 2 (segment fault) with linear address 0 and the decoded access bits.
- R7: Otherwise the status is 0 and the linear address is segment base + offset, modulo 2^32. Status 3 never appears.
- R8: `rq_ready` is high only while no request is in flight, and it is high after reset. A response stays valid and unchanged until it is taken with `rs_ready`.
- R9: `mem_req` and `mem_addr` stay steady until `mem_ack`. The read data is taken in the ack cycle, and any number of wait cycles is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tw_en | input | 1 | Table register write strobe |
| tw_sel | input | 1 | 0 = global, 1 = local table register |
| tw_base | input | 32 | Table base to load |
| tw_limit | input | 16 | Table limit to load |
| rq_valid | input | 1 | Request valid |
| rq_ready | output | 1 | Request accepted when high with valid |
| rq_sel | input | 16 | Segment selector |
| rq_off | input | 32 | Effective address |
| rs_valid | output | 1 | Response valid |
| rs_ready | input | 1 | Response taken |
| rs_linear | output | 32 | Linear address (0 on fault) |
| rs_rpl | output | 2 | Requested privilege level |
| rs_access | output | 12 | Descriptor access bits |
| rs_status | output | 2 | 0 ok, 1 table fault, 2 segment fault |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read done, data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
A table register write and the acceptance of a request can happen on the same clock edge. The bench provokes this by driving `tw_en` in the very cycle its request is accepted, shrinking the global limit. It expects that request to pass under the old limit and the next one to fault under the new limit. Around this, a sweep over both tables, every index up to just past each limit, and offsets at, below and just above each effective segment limit is judged against table and segment arithmetic recomputed in the bench. The sweep runs with varied memory latency and response backpressure.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W = 32;
  localparam int SEL_W  = 16;
  localparam int TLIM_W = 16;
  localparam int SLIM_W = 20;
  localparam int ACC_W  = 12;
  localparam int IDX_W  = SEL_W - 3;
  localparam int GSHIFT = 12;

  typedef enum logic [1:0] {ST_OK = 2'd0, ST_TBL = 2'd1, ST_SEG = 2'd2} xl_status_e;

  typedef struct packed {
    logic [ACC_W-1:0]  acc;
    logic              gran;
    logic [SLIM_W-1:0] limit;
    logic [ADDR_W-1:0] base;
  } desc_t;

  function automatic logic [ADDR_W-1:0] desc_addr(input logic [ADDR_W-1:0] tbase,
                                                   input logic [IDX_W-1:0] idx);
    return tbase + {{(ADDR_W-IDX_W-3){1'b0}}, idx, 3'b000};
  endfunction

  function automatic logic tbl_overrun(input logic [IDX_W-1:0] idx,
                                       input logic [TLIM_W-1:0] lim);
    return {idx, 3'b111} > lim;
  endfunction

  function automatic logic [ADDR_W-1:0] eff_limit(input logic [SLIM_W-1:0] lim,
                                                   input logic g);
    return g ? {lim, {GSHIFT{1'b1}}} : {{(ADDR_W-SLIM_W){1'b0}}, lim};
  endfunction

  function automatic desc_t unpack_desc(input logic [ADDR_W-1:0] lo,
                                        input logic [ADDR_W-1:0] hi);
    desc_t d;
    d.base  = lo;
    d.limit = hi[SLIM_W-1:0];
    d.gran  = hi[SLIM_W];
    d.acc   = {1'b0, hi[ADDR_W-1:SLIM_W+1]};
    return d;
  endfunction
endpackage

// File: rtl/seg_tblregs.sv
module seg_tblregs
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tw_en,
  input  logic              tw_sel,
  input  logic [ADDR_W-1:0] tw_base,
  input  logic [TLIM_W-1:0] tw_limit,
  input  logic              rd_ti,
  output logic [ADDR_W-1:0] rd_base,
  output logic [TLIM_W-1:0] rd_limit
);
  logic [ADDR_W-1:0] g_base_q, l_base_q;
  logic [TLIM_W-1:0] g_lim_q, l_lim_q;
  logic g_wr, l_wr;

  assign g_wr = tw_en && !tw_sel;
  assign l_wr = tw_en && tw_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_base_q <= '0; g_lim_q <= '0;
      l_base_q <= '0; l_lim_q <= '0;
    end else begin
      if (g_wr) begin g_base_q <= tw_base; g_lim_q <= tw_limit; end
      if (l_wr) begin l_base_q <= tw_base; l_lim_q <= tw_limit; end
    end
  end

  assign rd_base  = rd_ti ? l_base_q : g_base_q;
  assign rd_limit = rd_ti ? l_lim_q  : g_lim_q;

  // R2
  gload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    g_wr |=> (g_base_q == $past(tw_base)) && (g_lim_q == $past(tw_limit)));
  // R2
  lload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_wr |=> (l_base_q == $past(tw_base)) && (l_lim_q == $past(tw_limit)));
endmodule

// File: rtl/seg_walker.sv
module seg_walker
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic [SEL_W-1:0]  rq_sel,
  input  logic [ADDR_W-1:0] rq_off,
  output logic              tbl_ti,
  input  logic [ADDR_W-1:0] tbl_base,
  input  logic [TLIM_W-1:0] tbl_limit,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [ADDR_W-1:0] rs_linear,
  output logic [1:0]        rs_rpl,
  output logic [ACC_W-1:0]  rs_access,
  output logic [1:0]        rs_status
);
  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_READ_LO, S_READ_HI, S_DONE} wstate_e;

  wstate_e           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [1:0]        rpl_q;
  logic [ADDR_W-1:0] off_q, tbase_q, lo_q, lin_q;
  logic [TLIM_W-1:0] tlim_q;
  xl_status_e        stat_q;
  logic [ACC_W-1:0]  acc_q;

  logic              accept;
  logic [ADDR_W-1:0] daddr_w;
  logic              tbl_fault_w;
  desc_t             desc_w;
  logic              seg_fault_w;
  logic              lo_done, hi_done;

  assign rq_ready    = (st_q == S_IDLE);
  assign accept      = rq_valid && rq_ready;
  assign tbl_ti      = rq_sel[2];
  assign daddr_w     = desc_addr(tbase_q, idx_q);
  assign tbl_fault_w = (st_q == S_CHECK) && tbl_overrun(idx_q, tlim_q);
  assign desc_w      = unpack_desc(lo_q, mem_rdata);
  assign seg_fault_w = off_q > eff_limit(desc_w.limit, desc_w.gran);
  assign lo_done     = (st_q == S_READ_LO) && mem_ack;
  assign hi_done     = (st_q == S_READ_HI) && mem_ack;

  assign mem_req   = (st_q == S_READ_LO) || (st_q == S_READ_HI);
  assign mem_addr  = (st_q == S_READ_HI) ? daddr_w + 32'd4 : daddr_w;
  assign rs_valid  = (st_q == S_DONE);
  assign rs_linear = lin_q;
  assign rs_rpl    = rpl_q;
  assign rs_access = acc_q;
  assign rs_status = stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      idx_q <= '0; rpl_q <= '0; off_q <= '0;
      tbase_q <= '0; tlim_q <= '0; lo_q <= '0;
      lin_q <= '0; acc_q <= '0; stat_q <= ST_OK;
    end else begin
      case (st_q)
        S_IDLE: if (accept) begin
          idx_q   <= rq_sel[SEL_W-1:3];
          rpl_q   <= rq_sel[1:0];
          off_q   <= rq_off;
          tbase_q <= tbl_base;
          tlim_q  <= tbl_limit;
          st_q    <= S_CHECK;
        end
        S_CHECK: if (tbl_fault_w) begin
          stat_q <= ST_TBL; lin_q <= '0; acc_q <= '0;
          st_q   <= S_DONE;
        end else begin
          st_q <= S_READ_LO;
        end
        S_READ_LO: if (lo_done) begin
          lo_q <= mem_rdata;
          st_q <= S_READ_HI;
        end
        S_READ_HI: if (hi_done) begin
          acc_q  <= desc_w.acc;
          stat_q <= seg_fault_w ? ST_SEG : ST_OK;
          lin_q  <= seg_fault_w ? '0 : desc_w.base + off_q;
          st_q   <= S_DONE;
        end
        S_DONE: if (rs_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  // R8
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid && !rs_ready |=> rs_valid && $stable(rs_linear) && $stable(rs_status)
                               && $stable(rs_access) && $stable(rs_rpl));
  // R8
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !rq_ready);
  // R4
  tbl_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_fault_w |=> !mem_req && rs_valid);
  // R7
  status_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> rs_status != 2'd3);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tw_en,
  input  logic              tw_sel,
  input  logic [ADDR_W-1:0] tw_base,
  input  logic [TLIM_W-1:0] tw_limit,
  input  logic              rq_valid,
  output logic              rq_ready,
  input  logic [SEL_W-1:0]  rq_sel,
  input  logic [ADDR_W-1:0] rq_off,
  output logic              rs_valid,
  input  logic              rs_ready,
  output logic [ADDR_W-1:0] rs_linear,
  output logic [1:0]        rs_rpl,
  output logic [ACC_W-1:0]  rs_access,
  output logic [1:0]        rs_status,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata
);
  logic              sel_ti;
  logic [ADDR_W-1:0] sel_base;
  logic [TLIM_W-1:0] sel_limit;

  seg_tblregs u_regs (
    .clk(clk), .rst_n(rst_n),
    .tw_en(tw_en), .tw_sel(tw_sel), .tw_base(tw_base), .tw_limit(tw_limit),
    .rd_ti(sel_ti), .rd_base(sel_base), .rd_limit(sel_limit)
  );

  seg_walker u_walk (
    .clk(clk), .rst_n(rst_n),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_sel(rq_sel), .rq_off(rq_off),
    .tbl_ti(sel_ti), .tbl_base(sel_base), .tbl_limit(sel_limit),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_linear(rs_linear),
    .rs_rpl(rs_rpl), .rs_access(rs_access), .rs_status(rs_status)
  );
endmodule

// File: tb/seg_xlate_bench.sv
`timescale 1ns/1ps
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tw_en = 1'b0, tw_sel = 1'b0;
  logic [31:0] tw_base = '0;
  logic [15:0] tw_limit = '0;
  logic        rq_valid = 1'b0;
  logic        rq_ready;
  logic [15:0] rq_sel = '0;
  logic [31:0] rq_off = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b0;
  logic [31:0] rs_linear;
  logic [1:0]  rs_rpl;
  logic [11:0] rs_access;
  logic [1:0]  rs_status;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, failures = 0;
  int nreq = 0, wait_cnt = 0, lat = 0, txn = 0;
  logic [31:0] addr0 = '0, addr1 = '0;
  logic [31:0] g_base_m = '0, l_base_m = '0;
  logic [15:0] g_lim_m = '0, l_lim_m = '0;

  always #4 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst_n(rst_n),
    .tw_en(tw_en), .tw_sel(tw_sel), .tw_base(tw_base), .tw_limit(tw_limit),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_sel(rq_sel), .rq_off(rq_off),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_linear(rs_linear),
    .rs_rpl(rs_rpl), .rs_access(rs_access), .rs_status(rs_status),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // memory contents as a pure function of the address
  function automatic logic [31:0] memfn(input logic [31:0] a);
    return {a[7:0] ^ 8'h5A, 3'b000, a[4], 8'h00, a[11:0]};
  endfunction

  // memory model with varying wait cycles
  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_ack   <= 1'b1;
        mem_rdata <= memfn(mem_addr);
        if (nreq == 0) addr0 <= mem_addr; else addr1 <= mem_addr;
        nreq     <= nreq + 1;
        wait_cnt <= 0;
        txn      <= txn + 1;
        lat      <= (txn * 7) % 4;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_tbl(input logic sel, input logic [31:0] b, input logic [15:0] l);
    @(negedge clk);
    tw_en = 1'b1; tw_sel = sel; tw_base = b; tw_limit = l;
    @(negedge clk);
    tw_en = 1'b0;
    if (sel) begin l_base_m = b; l_lim_m = l; end else begin g_base_m = b; g_lim_m = l; end
  endtask

  // issue one request; optional table write in the accepting cycle;
  // expected values come from the model registers as they were before the write
  task automatic run_req(input logic ti, input int idx, input logic [1:0] rpl,
                         input logic [31:0] off, input int dly, input bit co_wr,
                         input logic [31:0] wb, input logic [15:0] wl, input string tag);
    logic [31:0] tb, da, lo, hi, el, exp_lin, exp_acc;
    logic [15:0] tl;
    logic [1:0]  exp_st;
    int          exp_n;
    int          guard;
    tb = ti ? l_base_m : g_base_m;
    tl = ti ? l_lim_m : g_lim_m;
    da = tb + 32'(idx) * 32'd8;
    lo = memfn(da);
    hi = memfn(da + 32'd4);
    el = hi[20] ? ((32'(hi[19:0]) * 32'd4096) + 32'd4095) : 32'(hi[19:0]);
    if (idx * 8 + 7 > int'(tl)) begin
      exp_st = 2'd1; exp_lin = 0; exp_acc = 0; exp_n = 0;
    end else if (off > el) begin
      exp_st = 2'd2; exp_lin = 0; exp_acc = {20'd0, 1'b0, hi[31:21]}; exp_n = 2;
    end else begin
      exp_st = 2'd0; exp_lin = lo + off; exp_acc = {20'd0, 1'b0, hi[31:21]}; exp_n = 2;
    end
    @(negedge clk);
    guard = 0;
    while (!rq_ready && guard < 100) begin @(negedge clk); guard++; end
    nreq = 0;
    rq_valid = 1'b1; rq_sel = {idx[12:0], ti, rpl}; rq_off = off;
    if (co_wr) begin tw_en = 1'b1; tw_sel = ti; tw_base = wb; tw_limit = wl; end
    @(negedge clk);
    rq_valid = 1'b0; tw_en = 1'b0;
    if (co_wr) begin
      if (ti) begin l_base_m = wb; l_lim_m = wl; end else begin g_base_m = wb; g_lim_m = wl; end
    end
    guard = 0;
    while (!rs_valid && guard < 100) begin @(negedge clk); guard++; end
    repeat (dly) @(negedge clk);
    chk({tag, " R7"}, "status", 32'(rs_status), 32'(exp_st));
    chk({tag, " R6"}, "linear", rs_linear, exp_lin);
    chk({tag, " R5"}, "access", 32'(rs_access), exp_acc);
    chk({tag, " R1"}, "rpl", 32'(rs_rpl), 32'(rpl));
    chk({tag, " R4"}, "reads", 32'(nreq), 32'(exp_n));
    if (exp_n == 2) begin
      chk({tag, " R3"}, "lo_addr", addr0, da);
      chk({tag, " R3"}, "hi_addr", addr1, da + 32'd4);
    end
    rs_ready = 1'b1;
    @(negedge clk);
    rs_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8", "rq_ready", 32'(rq_ready), 32'd1);
    chk("R8", "rs_valid", 32'(rs_valid), 32'd0);
    chk("R9", "mem_req", 32'(mem_req), 32'd0);
    // R2 reset registers are zero: index 0 overruns limit 0
    run_req(1'b0, 0, 2'd3, 32'd0, 0, 1'b0, 0, 0, "R2 reset");

    wr_tbl(1'b0, 32'h0000_2000, 16'h007F);
    wr_tbl(1'b1, 32'h0000_8004, 16'h003F);

    // R3 worked example: global index 2 descriptor at 0x2010
    run_req(1'b0, 2, 2'd3, 32'h10, 1, 1'b0, 0, 0, "R3 example");

    // sweep both tables past their limits, offsets at and around segment limit
    for (int ti = 0; ti < 2; ti++) begin
      for (int idx = 0; idx < 18; idx++) begin
        for (int m = 0; m < 3; m++) begin
          logic [31:0] da, hi, el, off;
          da = (ti ? l_base_m : g_base_m) + 32'(idx) * 32'd8;
          hi = memfn(da + 32'd4);
          el = hi[20] ? ((32'(hi[19:0]) << 12) | 32'hFFF) : 32'(hi[19:0]);
          off = (m == 0) ? 32'd0 : (m == 1) ? el : el + 32'd1;
          run_req(ti[0], idx, 2'(idx) ^ 2'(ti), off, (idx + m) % 3, 1'b0, 0, 0, "sweep R4 R6");
        end
      end
    end

    // R2 write in the accepting cycle: old limit used, new limit afterwards
    run_req(1'b0, 5, 2'd1, 32'd0, 0, 1'b1, 32'h0000_2000, 16'h0007, "R2 cowrite");
    run_req(1'b0, 5, 2'd1, 32'd0, 0, 1'b0, 0, 0, "R2 after");
    run_req(1'b0, 0, 2'd2, 32'd3, 0, 1'b0, 0, 0, "R2 idx0");
    // local table untouched by global write
    run_req(1'b1, 7, 2'd0, 32'd1, 2, 1'b0, 0, 0, "R2 local");

    // R3 wraparound of descriptor address
    wr_tbl(1'b0, 32'hFFFF_FFF8, 16'h00FF);
    run_req(1'b0, 1, 2'd0, 32'd5, 1, 1'b0, 0, 0, "R3 wrap");
    run_req(1'b0, 31, 2'd2, 32'd0, 0, 1'b0, 0, 0, "R4 edge");
    run_req(1'b0, 32, 2'd2, 32'd0, 0, 1'b0, 0, 0, "R4 over");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule